// File: doc/BRIEF.md
# Attribute-Gated Write Merging Buffer

This block sits on a 64-bit write path between an upstream requester and a downstream single-beat write port. Each upstream write is one beat with a valid/ready handshake. It carries an address, a size code, lane-aligned data, byte strobes and a 4-bit cache attribute. Upstream writes are posted, so each one counts as complete once the block accepts it.

Bit 1 of the cache attribute says whether a write may be modified. A modifiable write goes into a pending slot that covers one 8-byte aligned window. Later modifiable writes to the same window that carry an identical attribute are folded into that slot. The slot leaves the block as a single full-width write. A write with bit 1 clear targets device memory. It goes out exactly as it arrived, and only after any pending merged data has been issued.

The pending slot is flushed in four cases: a write to another window arrives, a write with a different attribute arrives, a device write arrives, or a programmable idle interval expires. An external flush request also flushes it. Whenever a flush is waiting for the output register, the upstream port holds ready low.

Top module: `wr_merge_buf`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: A write whose cache attribute has bit 1 at 0 is issued with the address, size, data, strobes and cache attribute it was received with, and is never combined with another write.
- R3: Modifiable writes to the same 8-byte aligned window with equal cache attributes leave as one write. That write has size code 3 (8 bytes) and address bits [2:0] at 0, and its cache attribute is that of the write that opened the window.
- R4: The strobe of a merged write is the OR of the strobes of its constituent writes. Data lanes that no constituent wrote are output as 0x00.
- R5: When a later merged write sets a lane that an earlier merged write already set, the later byte is output in that lane and the lane strobe stays 1.
- R6: A modifiable write to a different 8-byte window causes the pending write to be issued first. The new write then opens a fresh window.
- R7: A device write that arrives while merged data is pending is held until the pending write has been issued. It then follows, unchanged.
- R8: A modifiable write to the pending window whose cache attribute differs from the window's attribute flushes the pending write and opens a new window; it does not join the pending one.
- R9: With idle_limit_i = L and the output free, the pending write is presented on the output L+1 clock edges after the last mergeable write was accepted.
- R10: A 1 on flush_i issues the pending write, and it wins over an input presented in the same cycle, which is accepted afterwards into a new window. flush_i with nothing pending produces no output.
- R11: While out_valid_o is 1 and out_ready_i is 0, all output fields hold steady and in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Upstream write valid |
| in_ready_o | output | 1 | Upstream write ready |
| in_addr_i | input | ADDR_W | Upstream byte address |
| in_size_i | input | 3 | Upstream size code (log2 of bytes) |
| in_data_i | input | 64 | Upstream data, lane aligned |
| in_strb_i | input | 8 | Upstream byte strobes |
| in_cache_i | input | 4 | Upstream cache attribute; bit 1 = modifiable |
| flush_i | input | 1 | Request to issue the pending merged write |
| idle_limit_i | input | IDLE_W | Idle cycles before an automatic flush |
| out_valid_o | output | 1 | Downstream write valid |
| out_ready_i | input | 1 | Downstream write ready |
| out_addr_o | output | ADDR_W | Downstream address |
| out_size_o | output | 3 | Downstream size code |
| out_data_o | output | 64 | Downstream data |
| out_strb_o | output | 8 | Downstream byte strobes |
| out_cache_o | output | 4 | Downstream cache attribute |

## Verification
In one cycle an external flush and a new mergeable write to the same window can both be presented. The same collision occurs between an idle-timer expiry or a device write and pending data. The bench raises flush_i in the same cycle that it presents a write to the window that is already pending. It then checks that two separate transactions come out, the old window first and the new write alone after it. A sweep over every 8-bit lane pattern, built from single-byte writes, checks the merged strobe and data against values computed arithmetically.

// File: rtl/wm_pkg.sv
package wm_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned LANES  = 8;
  localparam int unsigned DATA_W  = LANES * 8;
  localparam int unsigned OFS_W   = $clog2(LANES);
  localparam int unsigned MOD_BIT = 1;
  localparam logic [2:0] SIZE_FULL = 3'(OFS_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [2:0]        size;
    logic [DATA_W-1:0] data;
    logic [LANES-1:0]  strb;
    logic [3:0]        cache;
  } wr_req_t;
endpackage

// File: rtl/wm_lane_merge.sv
module wm_lane_merge
  import wm_pkg::*;
(
  input  logic              open_i,
  input  logic [DATA_W-1:0] old_data_i,
  input  logic [LANES-1:0]  old_strb_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [LANES-1:0]  in_strb_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  strb_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // newest byte wins; a fresh window zeroes lanes nobody wrote
    assign data_o[l*8 +: 8] = in_strb_i[l] ? in_data_i[l*8 +: 8] :
                              open_i       ? 8'h00 : old_data_i[l*8 +: 8];
    assign strb_o[l] = in_strb_i[l] | (~open_i & old_strb_i[l]);
  end
endmodule

// File: rtl/wm_idle_timer.sv
module wm_idle_timer #(
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [IDLE_W-1:0] limit_i,
  output logic              hit_o
);
  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || !run_i)         cnt_q <= '0;
    else if (cnt_q != {IDLE_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/wm_out_stage.sv
module wm_out_stage
  import wm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  wr_req_t req_i,
  input  logic    ready_i,
  output logic    valid_o,
  output wr_req_t req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      req_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      req_o   <= req_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wr_merge_buf.sv
module wr_merge_buf
  import wm_pkg::*;
#(
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [2:0]        in_size_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [LANES-1:0]  in_strb_i,
  input  logic [3:0]        in_cache_i,
  input  logic              flush_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [2:0]        out_size_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [LANES-1:0]  out_strb_o,
  output logic [3:0]        out_cache_o
);
  wr_req_t pend_q, in_req, out_req, load_req;
  logic    pend_vld_q;
  logic    is_mod, same_win, same_attr, conflict, timer_hit, flush_now;
  logic    accept, acc_mod, acc_dev;
  logic [ADDR_W-1:0] in_base;
  logic [DATA_W-1:0] mrg_data;
  logic [LANES-1:0]  mrg_strb;

  assign in_req = '{addr: in_addr_i, size: in_size_i, data: in_data_i,
                    strb: in_strb_i, cache: in_cache_i};

  assign is_mod    = in_cache_i[MOD_BIT];
  assign in_base   = {in_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign same_win  = (pend_q.addr == in_base);
  assign same_attr = (pend_q.cache == in_cache_i);
  assign conflict  = in_valid_i && (!is_mod || !same_win || !same_attr);

  // a flush owns the cycle; the input waits until it has gone out
  assign flush_now  = pend_vld_q && !out_valid_o && (flush_i || timer_hit || conflict);
  assign in_ready_o = !out_valid_o && !flush_now;
  assign accept     = in_valid_i && in_ready_o;
  assign acc_mod    = accept && is_mod;
  assign acc_dev    = accept && !is_mod;

  wm_lane_merge u_merge (
    .open_i     (!pend_vld_q),
    .old_data_i (pend_q.data),
    .old_strb_i (pend_q.strb),
    .in_data_i  (in_data_i),
    .in_strb_i  (in_strb_i),
    .data_o     (mrg_data),
    .strb_o     (mrg_strb)
  );

  wm_idle_timer #(.IDLE_W(IDLE_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (pend_vld_q),
    .clr_i   (acc_mod || flush_now),
    .limit_i (idle_limit_i),
    .hit_o   (timer_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else if (flush_now) begin
      pend_vld_q <= 1'b0;
    end else if (acc_mod) begin
      pend_vld_q <= 1'b1;
      pend_q     <= '{addr: in_base, size: SIZE_FULL, data: mrg_data,
                      strb: mrg_strb, cache: in_cache_i};
    end
  end

  assign load_req = flush_now ? pend_q : in_req;

  wm_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (flush_now || acc_dev),
    .req_i   (load_req),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .req_o   (out_req)
  );

  assign out_addr_o  = out_req.addr;
  assign out_size_o  = out_req.size;
  assign out_data_o  = out_req.data;
  assign out_strb_o  = out_req.strb;
  assign out_cache_o = out_req.cache;
endmodule

module wr_merge_buf_chk
  import wm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [3:0]        in_cache_i,
  input logic              flush_i,
  input logic              pend_vld_q,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [2:0]        out_size_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [LANES-1:0]  out_strb_o,
  input logic [3:0]        out_cache_o
);
  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o) &&
      $stable(out_size_o) && $stable(out_data_o) && $stable(out_strb_o) &&
      $stable(out_cache_o));
  // R11
  in_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  // R7
  dev_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !in_cache_i[MOD_BIT] |-> !pend_vld_q);
  // R3
  full_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_cache_o[MOD_BIT] |->
      out_size_o == SIZE_FULL && out_addr_o[OFS_W-1:0] == '0);
  // R4
  strb_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_cache_o[MOD_BIT] |-> out_strb_o != '0);
  // R10
  flush_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && pend_vld_q && !out_valid_o |=> out_valid_o);
endmodule

bind wr_merge_buf wr_merge_buf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_cache_i  (in_cache_i),
  .flush_i     (flush_i),
  .pend_vld_q  (pend_vld_q),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_addr_o  (out_addr_o),
  .out_size_o  (out_size_o),
  .out_data_o  (out_data_o),
  .out_strb_o  (out_strb_o),
  .out_cache_o (out_cache_o)
);

// File: tb/wr_merge_buf_bench.sv
module wr_merge_buf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_addr_i = '0;
  logic [2:0]  in_size_i = '0;
  logic [63:0] in_data_i = '0;
  logic [7:0]  in_strb_i = '0;
  logic [3:0]  in_cache_i = '0;
  logic        flush_i = 1'b0;
  logic [7:0]  idle_limit_i = 8'd255;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_addr_o;
  logic [2:0]  out_size_o;
  logic [63:0] out_data_o;
  logic [7:0]  out_strb_o;
  logic [3:0]  out_cache_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  wr_merge_buf u_wr_merge_buf (.*);

  // capture ring, sampled at the falling edge
  logic [31:0] c_addr [16];
  logic [2:0]  c_size [16];
  logic [63:0] c_data [16];
  logic [7:0]  c_strb [16];
  logic [3:0]  c_cache[16];
  int cap_n = 0;

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      c_addr[cap_n % 16]  <= out_addr_o;
      c_size[cap_n % 16]  <= out_size_o;
      c_data[cap_n % 16]  <= out_data_o;
      c_strb[cap_n % 16]  <= out_strb_o;
      c_cache[cap_n % 16] <= out_cache_o;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input int idx, input logic [31:0] a, input logic [2:0] s,
                         input logic [63:0] d, input logic [7:0] st, input logic [3:0] c,
                         input string req);
    int k;
    k = idx % 16;
    chk(c_addr[k] == a, {req, " addr"}, 64'(c_addr[k]), 64'(a));
    chk(c_data[k] == d, {req, " data"}, c_data[k], d);
    chk(c_strb[k] == st, {req, " strb"}, 64'(c_strb[k]), 64'(st));
    chk({c_size[k], c_cache[k]} == {s, c}, {req, " size/cache"},
        64'({c_size[k], c_cache[k]}), 64'({s, c}));
  endtask

  task automatic send(input logic [31:0] a, input logic [2:0] s, input logic [63:0] d,
                      input logic [7:0] st, input logic [3:0] c, input bit fl);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_addr_i = a; in_size_i = s; in_data_i = d;
    in_strb_i = st; in_cache_i = c; flush_i = fl;
    #1;
    while (!in_ready_o) begin
      @(negedge clk_i);
      flush_i = 1'b0;
      #1;
    end
    @(posedge clk_i);
    #1;
    in_valid_i = 1'b0;
    flush_i = 1'b0;
  endtask

  task automatic send_byte(input logic [31:0] a, input logic [7:0] v, input logic [3:0] c);
    send(a, 3'd0, 64'(v) << (8 * a[2:0]), 8'(1) << a[2:0], c, 1'b0);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk_i);
    while (out_valid_o) @(negedge clk_i);
  endtask

  task automatic do_flush();
    drain();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 64'(0), 64'(1));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base_n;
    int k;
    logic [63:0] exp_d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(out_valid_o == 1'b0, "R1 out_valid", 64'(out_valid_o), 64'(0));
    chk(in_ready_o == 1'b1, "R1 in_ready", 64'(in_ready_o), 64'(1));

    // R3 R4: every lane pattern built from single-byte writes
    for (int m = 1; m < 256; m++) begin
      base_n = cap_n;
      exp_d = '0;
      for (int i = 0; i < 8; i++) begin
        if (m[i]) begin
          send_byte(32'h1000 + 32'(m * 8 + i), 8'(m + i * 37), 4'h3);
          exp_d[i*8 +: 8] = 8'(m + i * 37);
        end
      end
      do_flush();
      chk(cap_n == base_n + 1, "R3 one output per window", 64'(cap_n - base_n), 64'(1));
      k = base_n % 16;
      chk(c_strb[k] == 8'(m) && c_data[k] == exp_d && c_addr[k] == 32'h1000 + 32'(m * 8)
          && c_size[k] == 3'd3, "R4 lane sweep", c_data[k], exp_d);
    end

    // R3 R4 example: bytes at offsets 0, 4, 5
    base_n = cap_n;
    send_byte(32'h2000, 8'hA0, 4'h2);
    send_byte(32'h2004, 8'hA4, 4'h2);
    send_byte(32'h2005, 8'hA5, 4'h2);
    do_flush();
    chk_out(base_n, 32'h2000, 3'd3, 64'h0000_A5A4_0000_00A0, 8'h31, 4'h2, "R3");

    // R5 lane overwrite
    base_n = cap_n;
    send_byte(32'h3002, 8'h11, 4'h3);
    send(32'h3002, 3'd1, 64'h0000_0000_3322_0000, 8'h0C, 4'h3, 1'b0);
    do_flush();
    chk_out(base_n, 32'h3000, 3'd3, 64'h0000_0000_3322_0000, 8'h0C, 4'h3, "R5");

    // R6 window change
    base_n = cap_n;
    send_byte(32'h4001, 8'h5A, 4'h3);
    send_byte(32'h4008, 8'h6B, 4'h3);
    do_flush();
    chk(cap_n == base_n + 2, "R6 count", 64'(cap_n - base_n), 64'(2));
    chk_out(base_n, 32'h4000, 3'd3, 64'h5A00, 8'h02, 4'h3, "R6 first");
    chk_out(base_n + 1, 32'h4008, 3'd3, 64'h6B, 8'h01, 4'h3, "R6 second");

    // R2 R7 device write behind pending data
    base_n = cap_n;
    send_byte(32'h5000, 8'h77, 4'h3);
    send(32'h5005, 3'd0, 64'h0000_9900_0000_0000, 8'h20, 4'h1, 1'b0);
    drain();
    chk(cap_n == base_n + 2, "R7 count", 64'(cap_n - base_n), 64'(2));
    chk_out(base_n, 32'h5000, 3'd3, 64'h77, 8'h01, 4'h3, "R7 pending first");
    chk_out(base_n + 1, 32'h5005, 3'd0, 64'h0000_9900_0000_0000, 8'h20, 4'h1, "R2 device unchanged");

    // R2 back-to-back device writes to the same window stay separate
    base_n = cap_n;
    send_byte(32'h5100, 8'h01, 4'h0);
    send_byte(32'h5101, 8'h02, 4'h0);
    drain();
    chk(cap_n == base_n + 2, "R2 no merge", 64'(cap_n - base_n), 64'(2));
    chk_out(base_n + 1, 32'h5101, 3'd0, 64'h0200, 8'h02, 4'h0, "R2 second device");

    // R8 attribute mismatch
    base_n = cap_n;
    send_byte(32'h6000, 8'h10, 4'h3);
    send_byte(32'h6001, 8'h20, 4'hF);
    do_flush();
    chk(cap_n == base_n + 2, "R8 count", 64'(cap_n - base_n), 64'(2));
    chk_out(base_n, 32'h6000, 3'd3, 64'h10, 8'h01, 4'h3, "R8 first");
    chk_out(base_n + 1, 32'h6000, 3'd3, 64'h2000, 8'h02, 4'hF, "R8 second");

    // R9 idle flush timing
    for (int lim = 0; lim < 6; lim += 2) begin
      idle_limit_i = 8'(lim);
      send_byte(32'h7003, 8'h3C, 4'h3);
      k = 0;
      while (k < 50) begin
        @(negedge clk_i);
        k++;
        if (out_valid_o) break;
      end
      chk(k == lim + 2, "R9 idle flush delay", 64'(k), 64'(lim + 2));
      drain();
    end
    idle_limit_i = 8'd255;

    // R10 flush with nothing pending
    base_n = cap_n;
    do_flush();
    chk(cap_n == base_n && !out_valid_o, "R10 empty flush", 64'(cap_n - base_n), 64'(0));

    // R10 flush colliding with a same-window write
    base_n = cap_n;
    send_byte(32'h8000, 8'hE1, 4'h3);
    send(32'h8001, 3'd0, 64'hE200, 8'h02, 4'h3, 1'b1);
    do_flush();
    chk(cap_n == base_n + 2, "R10 collision count", 64'(cap_n - base_n), 64'(2));
    chk_out(base_n, 32'h8000, 3'd3, 64'hE1, 8'h01, 4'h3, "R10 old window");
    chk_out(base_n + 1, 32'h8000, 3'd3, 64'hE200, 8'h02, 4'h3, "R10 new window");

    // R11 backpressure
    base_n = cap_n;
    out_ready_i = 1'b0;
    send(32'h9006, 3'd1, 64'hBEEF_0000_0000_0000, 8'hC0, 4'h0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(out_valid_o && !in_ready_o && out_addr_o == 32'h9006 &&
          out_data_o == 64'hBEEF_0000_0000_0000 && out_strb_o == 8'hC0,
          "R11 hold", out_data_o, 64'hBEEF_0000_0000_0000);
    end
    out_ready_i = 1'b1;
    drain();
    chk(cap_n == base_n + 1, "R11 released", 64'(cap_n - base_n), 64'(1));
    chk_out(base_n, 32'h9006, 3'd1, 64'hBEEF_0000_0000_0000, 8'hC0, 4'h0, "R11");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule